// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block chooses the operating mode of a single-channel differential bus transceiver from two asynchronous host command pins. Both pins are brought into the free-running internal oscillator domain through a synchronizer and then debounced, so a pin change reaches the mode logic only once it has held for a set number of oscillator periods. The filtered pair is decoded into one of five modes. A request to sleep passes through a timed pre-sleep dwell. If the second pin follows the first low within that dwell, the request turns into a plain standby, and the controller commits to sleep only once the dwell has run out.

The block also drives an enable for an external supply regulator, which stays on in every mode except sleep. A wake event input brings the controller from sleep back to standby. Undriven host pins read low, and a low/low pair decodes as standby. The controller therefore parks safely when the host releases its pins.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high) leaves `mode_o` at standby (code 1) with `reg_en_o` high. While both command pins stay low after reset, the mode stays standby.
- R2: With the defaults (2 synchronizer stages, 3-sample debounce), a command pin change driven between two clock edges first shows on `mode_o` after the sixth following rising edge. After the fifth edge the old mode is still visible.
- R3: A command pin excursion held for fewer than 3 oscillator periods is ignored and does not change the mode. An excursion held for 3 periods is accepted.
- R4: Filtered `cmd_live_i`=1 selects normal (code 4) when `cmd_full_i`=1 and listen-only (code 3) when `cmd_full_i`=0. This decode applies from every mode, sleep included, and from sleep it goes there directly.
- R5: From normal, listen-only or standby, filtered `cmd_live_i`=0 with `cmd_full_i`=0 gives standby (code 1). If both pins fall together, the pre-sleep mode is never visited.
- R6: Filtered `cmd_live_i`=0 with `cmd_full_i`=1 gives pre-sleep (code 2). If `cmd_full_i` falls 1 or 2 periods after `cmd_live_i` (the default dwell of 2), the result is standby.
- R7: If pre-sleep lasts longer than the dwell (`cmd_full_i` falling 3 or more periods after `cmd_live_i`), the mode becomes sleep (code 0). In sleep, `cmd_full_i` is ignored.
- R8: `reg_en_o` is low in sleep and high in every other mode.
- R9: A one-cycle `wake_i` pulse while in sleep with `cmd_live_i` low gives standby after the next rising edge. In any other mode it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_live_i | input | 1 | Asynchronous host pin: high leaves the low-power modes |
| cmd_full_i | input | 1 | Asynchronous host pin: selects full operation or the sleep request |
| wake_i | input | 1 | Wake event, synchronous to `clk` |
| mode_o | output | 3 | Mode: 0 sleep, 1 standby, 2 pre-sleep, 3 listen-only, 4 normal |
| reg_en_o | output | 1 | Regulator enable, low only in sleep |

## Verification
The decode is exercised with all four pin pairs. The pins are changed together and one after the other with skews of 0 to 3 periods, which separates a direct standby from a pre-sleep that falls back to standby or that commits to sleep. Pulses of 2 and 3 periods mark the boundary of the debounce. The bench first counts the latency edge by edge, then runs random held pin pairs mixed with wake pulses. These show whether the controller ignores the second pin in sleep, and whether a wake acts only there.

// File: rtl/xmc_pkg.sv
package xmc_pkg;
   typedef enum logic [2:0] {
      M_SLEEP    = 3'd0,
      M_STANDBY  = 3'd1,
      M_PRESLEEP = 3'd2,
      M_LISTEN   = 3'd3,
      M_NORMAL   = 3'd4
   } mode_e;
endpackage

// File: rtl/xmc_pin_filter.sv
module xmc_pin_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic pin_i,
   output logic lvl_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xmc_pin_filter: SYNC_STAGES must be at least 2");
   end
   if (DEB_CYCLES < 1) begin : g_bad_deb
      $error("xmc_pin_filter: DEB_CYCLES must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   sync_out;
   logic                   lvl_q;

   always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end
   assign sync_out = sync_q[SYNC_STAGES-1];

   if (DEB_CYCLES == 1) begin : g_direct
      always_ff @(posedge clk) begin
         if (rst) lvl_q <= 1'b0;
         else     lvl_q <= sync_out;
      end
   end else begin : g_count
      localparam int CW = $clog2(DEB_CYCLES);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q <= '0;
            lvl_q <= 1'b0;
         end else if (sync_out == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CW'(DEB_CYCLES - 1)) begin
            cnt_q <= '0;
            lvl_q <= sync_out;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign lvl_o = lvl_q;

   // R2: the filtered level only ever takes the synchronized value
   a_r2_from_sync: assert property (@(posedge clk) disable iff (rst)
      !$stable(lvl_q) |-> (lvl_q == $past(sync_out)));
   // R3: no change while the synchronized input agrees with the filter
   a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
      (sync_out == lvl_q) |=> $stable(lvl_q));
endmodule

// File: rtl/xmc_mode_fsm.sv
module xmc_mode_fsm
   import xmc_pkg::*;
#(
   parameter int GTS_CYCLES = 2
) (
   input  logic  clk,
   input  logic  rst,
   input  logic  live_i,
   input  logic  full_i,
   input  logic  wake_i,
   output mode_e mode_o,
   output logic  reg_en_o
);
   if (GTS_CYCLES < 1) begin : g_bad_gts
      $error("xmc_mode_fsm: GTS_CYCLES must be at least 1");
   end

   localparam int TW = $clog2(GTS_CYCLES + 1);

   mode_e         state_q, state_d;
   logic [TW-1:0] gts_q, gts_d;
   logic          reg_en_q;

   always_comb begin
      state_d = state_q;
      gts_d   = '0;
      if (live_i) begin
         state_d = full_i ? M_NORMAL : M_LISTEN;
      end else begin
         case (state_q)
            M_SLEEP: begin
               if (wake_i) state_d = M_STANDBY;
            end
            M_STANDBY, M_NORMAL, M_LISTEN: begin
               state_d = full_i ? M_PRESLEEP : M_STANDBY;
            end
            M_PRESLEEP: begin
               if (!full_i) begin
                  state_d = M_STANDBY;
               end else if (gts_q == TW'(GTS_CYCLES - 1)) begin
                  state_d = M_SLEEP;
               end else begin
                  gts_d = gts_q + 1'b1;
               end
            end
            default: state_d = M_STANDBY;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q  <= M_STANDBY;
         gts_q    <= '0;
         reg_en_q <= 1'b1;
      end else begin
         state_q  <= state_d;
         gts_q    <= gts_d;
         reg_en_q <= (state_d != M_SLEEP);
      end
   end

   assign mode_o   = state_q;
   assign reg_en_o = reg_en_q;

   // R4: host decode with the live pin high wins in every mode
   a_r4_decode: assert property (@(posedge clk) disable iff (rst)
      live_i |=> (state_q == ($past(full_i) ? M_NORMAL : M_LISTEN)));
   // R5: both pins low outside sleep and pre-sleep give standby
   a_r5_standby: assert property (@(posedge clk) disable iff (rst)
      ((state_q == M_NORMAL || state_q == M_LISTEN || state_q == M_STANDBY)
       && !live_i && !full_i) |=> (state_q == M_STANDBY));
   // R6: the dwell counter stays inside the pre-sleep window
   a_r6_dwell: assert property (@(posedge clk) disable iff (rst)
      (state_q == M_PRESLEEP) |-> (gts_q < TW'(GTS_CYCLES)));
   // R7: sleep is entered only from pre-sleep
   a_r7_entry: assert property (@(posedge clk) disable iff (rst)
      (state_q == M_SLEEP && $past(state_q) != M_SLEEP) |-> ($past(state_q) == M_PRESLEEP));
   // R7: in sleep the full pin has no effect
   a_r7_full_ignored: assert property (@(posedge clk) disable iff (rst)
      (state_q == M_SLEEP && !live_i && !wake_i) |=> (state_q == M_SLEEP));
   // R8: the regulator enable is released only in sleep
   a_r8_release: assert property (@(posedge clk) disable iff (rst)
      !reg_en_q |-> (state_q == M_SLEEP));
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      (state_q == M_SLEEP) |-> !reg_en_q);
   // R9: wake leaves sleep for standby
   a_r9_wake: assert property (@(posedge clk) disable iff (rst)
      (state_q == M_SLEEP && !live_i && wake_i) |=> (state_q == M_STANDBY));
endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
   import xmc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 3,
   parameter int GTS_CYCLES  = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       cmd_live_i,
   input  logic       cmd_full_i,
   input  logic       wake_i,
   output logic [2:0] mode_o,
   output logic       reg_en_o
);
   logic  live_f, full_f;
   mode_e mode_w;

   xmc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_live_flt (
      .clk(clk), .rst(rst), .pin_i(cmd_live_i), .lvl_o(live_f));

   xmc_pin_filter #(.SYNC_STAGES(SYNC_STAGES), .DEB_CYCLES(DEB_CYCLES)) u_full_flt (
      .clk(clk), .rst(rst), .pin_i(cmd_full_i), .lvl_o(full_f));

   xmc_mode_fsm #(.GTS_CYCLES(GTS_CYCLES)) u_fsm (
      .clk(clk), .rst(rst), .live_i(live_f), .full_i(full_f), .wake_i(wake_i),
      .mode_o(mode_w), .reg_en_o(reg_en_o));

   assign mode_o = mode_w;

   // R1: reset parks the controller in standby with the regulator on
   a_r1_reset: assert property (@(posedge clk)
      $past(rst) |-> (mode_o == 3'd1 && reg_en_o));
endmodule

// File: tb/xcvr_mode_ctrl_tb.sv
module xcvr_mode_ctrl_tb;
   localparam int SLP = 0, STB = 1, PRE = 2, LIS = 3, NRM = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       live = 1'b0, full = 1'b0, wake = 1'b0;
   logic [2:0] mode;
   logic       reg_en;
   int         n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   xcvr_mode_ctrl u_dut (
      .clk(clk), .rst(rst), .cmd_live_i(live), .cmd_full_i(full), .wake_i(wake),
      .mode_o(mode), .reg_en_o(reg_en));

   task automatic check(string tag, int act, int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   // settled mode after a pin pair has been held long enough
   function automatic int settle(int prev, logic l, logic f);
      if (l) return f ? NRM : LIS;
      if (prev == SLP) return SLP;
      return f ? SLP : STB;
   endfunction

   task automatic go_normal();
      live = 1'b1; full = 1'b1;
      tick(12);
      check("R4 normal", mode, NRM);
   endtask

   // live falls, full falls d periods later; returns whether pre-sleep was seen
   task automatic skew(int d, int exp_final, bit exp_pre, string tag);
      bit saw = 0;
      live = 1'b0;
      for (int i = 0; i < d; i++) begin
         tick(1);
         if (mode == PRE) saw = 1;
      end
      full = 1'b0;
      for (int i = 0; i < 16; i++) begin
         tick(1);
         if (mode == PRE) saw = 1;
      end
      check({tag, " final"}, mode, exp_final);
      check({tag, " pre-sleep seen"}, saw, exp_pre);
      check("R8 enable", reg_en, (exp_final == SLP) ? 0 : 1);
   endtask

   initial begin
      int exp;
      int prev;
      bit saw;
      void'($urandom(32'd20240611));
      tick(3);
      rst = 1'b0;
      tick(1);
      check("R1 reset mode", mode, STB);
      check("R1 reset enable", reg_en, 1);
      tick(10);
      check("R1 pins low stay standby", mode, STB);

      // R2 latency: old mode after 5 edges, new after 6
      live = 1'b1; full = 1'b1;
      tick(5);
      check("R2 before latency", mode, STB);
      tick(1);
      check("R2 at latency", mode, NRM);

      // R3 two-period glitch rejected
      live = 1'b0;
      tick(2);
      live = 1'b1;
      saw = 0;
      for (int i = 0; i < 12; i++) begin
         tick(1);
         if (mode != NRM) saw = 1;
      end
      check("R3 short pulse ignored", saw, 0);

      // R3 three-period pulse accepted (full high -> pre-sleep, sleep, back)
      live = 1'b0;
      saw = 0;
      for (int i = 0; i < 3; i++) begin
         tick(1);
         if (mode == PRE) saw = 1;
      end
      live = 1'b1;
      for (int i = 0; i < 14; i++) begin
         tick(1);
         if (mode == PRE) saw = 1;
      end
      check("R3 three-period pulse accepted", saw, 1);
      check("R4 back to normal", mode, NRM);

      // R4 listen-only
      full = 1'b0;
      tick(12);
      check("R4 listen-only", mode, LIS);

      // R5 simultaneous fall from normal
      go_normal();
      skew(0, STB, 0, "R5 simultaneous");
      // R6 short skews
      go_normal();
      skew(1, STB, 1, "R6 skew 1");
      go_normal();
      skew(2, STB, 1, "R6 skew 2");
      // R7 long skew commits to sleep
      go_normal();
      skew(3, SLP, 1, "R7 skew 3");

      // R7 full pin ignored in sleep
      full = 1'b1; tick(12);
      check("R7 full high ignored", mode, SLP);
      full = 1'b0; tick(12);
      check("R7 full low ignored", mode, SLP);
      check("R8 sleep enable", reg_en, 0);

      // R9 wake in sleep
      wake = 1'b1; tick(1); wake = 1'b0;
      check("R9 wake to standby", mode, STB);
      check("R8 enable after wake", reg_en, 1);

      // R9 wake without effect in normal
      go_normal();
      wake = 1'b1; tick(1); wake = 1'b0; tick(1);
      check("R9 wake ignored in normal", mode, NRM);

      // R4 sleep straight to listen-only
      live = 1'b1; full = 1'b0; tick(12);
      live = 1'b0; full = 1'b1; tick(14);
      check("R7 sleep via request", mode, SLP);
      live = 1'b1; full = 1'b0;
      saw = 0;
      for (int i = 0; i < 12; i++) begin
         tick(1);
         if (mode != SLP && mode != LIS) saw = 1;
      end
      check("R4 sleep direct to listen-only", saw, 0);
      check("R4 listen-only from sleep", mode, LIS);

      // random held pairs with wake pulses
      prev = LIS;
      for (int it = 0; it < 60; it++) begin
         live = 1'($urandom_range(0, 1));
         full = 1'($urandom_range(0, 1));
         tick(14);
         exp = settle(prev, live, full);
         check("R4/R5/R7 random settle", mode, exp);
         check("R8 random enable", reg_en, (exp == SLP) ? 0 : 1);
         prev = exp;
         if (!(live == 1'b0 && full == 1'b1) && $urandom_range(0, 1) == 1) begin
            wake = 1'b1; tick(1); wake = 1'b0; tick(1);
            if (prev == SLP && !live) exp = STB;
            check("R9 random wake", mode, exp);
            prev = exp;
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule